// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Sequencer

This block sits between an on-chip host and an external asynchronous static RAM of 512K words by 32 bits, split into four byte lanes. The host presents a single request carrying a direction flag, a word address, write data and four active-high lane enables. The sequencer then walks the memory pins through setup, active and hold windows whose lengths are counted in clock cycles. When a transfer finishes it raises a one-cycle completion pulse and, for reads, presents the captured word.

While nothing is pending, the memory is deselected and the controller releases the data bus. A write that starts from this standby state first selects the chip with output enable and write enable both high, so that the memory's drivers turn off before the controller drives data. Once a write finishes, write enable stays low for one extra cycle, the completion cycle. A further write issued in that cycle reuses the low write enable, and only the byte strobes frame the new word. A read issued in that cycle releases write enable and the bus and goes straight into its own setup. If nothing is issued in that cycle, the memory returns to standby.

A request is taken only while the sequencer is idle or in the write completion cycle. The host issues one request and waits for completion before it issues the next. A request whose lane enables are all clear completes on the next cycle without touching any strobe.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Out of reset, and whenever no transfer is in progress, the pins rest in standby: chip enable `sram_ce_n` is high, `sram_ce2` is low, `sram_oe_n` and `sram_we_n` are high, all of `sram_bw_n` are high and `sram_dq_oe` is 0.
- R2: A read runs SETUP_CYC cycles with the chip selected and output enable and strobes high. It then runs READ_CYC cycles with `sram_oe_n` low and `sram_bw_n` equal to the inverse of the lane enables, then HOLD_CYC cycles with output enable and strobes high, and then returns to standby.
- R3: `rd_data` takes the whole `sram_dq_in` word sampled in the last output-enable cycle. It becomes valid in the completion cycle and holds until the next read with at least one lane enable set.
- R4: A write from standby runs TURN_CYC cycles selected with write enable, output enable and strobes high and the bus released. It then runs SETUP_CYC cycles with `sram_we_n` low, data driven and strobes high, then PULSE_CYC cycles with the strobes equal to the inverse of the lane enables, then HOLD_CYC cycles with strobes high, and then one completion cycle in which write enable stays low.
- R5: A write issued in a write's completion cycle skips the turnaround and starts directly at its setup window, and `sram_we_n` stays low throughout.
- R6: If no request arrives in a write's completion cycle, the next cycle is in standby.
- R7: `sram_dq_oe` is 1 only while `sram_we_n` is low and `sram_oe_n` is high, and never at the same time as an output-enable cycle.
- R8: `done` is high for one cycle per request. For a read this is the cycle after the hold window. For a write it is the completion cycle.
- R9: A request with all lane enables 0 raises `done` in the next cycle with all strobes high. After a write's completion cycle, such a write keeps write enable low for one further completion cycle. In every other case it leaves the memory in standby.
- R10: A read issued in a write's completion cycle starts at its setup window with `sram_we_n` high and the bus released.
- R11: Lane enable bit k and strobe `sram_bw_n[k]` cover data bits 8k+7 down to 8k. Bit 0 is bits 7:0 and bit 3 is bits 31:24.
- R12: Address and write data are captured when a request is accepted and stay constant on `sram_addr` and `sram_dq_out` for the whole transfer.
- R13: A request presented while a transfer is in progress, outside its completion cycle, is ignored: it changes neither the pin sequence nor the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, one cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Active-high lane enables |
| rd_data | output | 32 | Captured read word |
| done | output | 1 | Completion pulse |
| sram_addr | output | 19 | Memory address |
| sram_ce_n | output | 1 | Active-low chip enable |
| sram_ce2 | output | 1 | Active-high chip enable |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_bw_n | output | 4 | Active-low byte-lane strobes |
| sram_dq_out | output | 32 | Data driven to the memory |
| sram_dq_in | input | 32 | Data returned from the memory |
| sram_dq_oe | output | 1 | Tristate enable for `sram_dq_out` |

## Verification
The hardest situation to reach is the write completion cycle, a single-cycle window. Only there does a new request see write enable still low, so that back-to-back framing, zero-lane writes that extend the window and reads that must release the bus can all occur. The stimulus waits for `done` and issues the next request in that same cycle. It chains write, write, empty write and read so that each branch out of that cycle is taken. A model of the memory in the bench is built from the pins alone. Reads after these chains show whether the right lanes were written.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW        = 19,
  parameter int DW        = 32,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter int TURN_CYC  = 1,
  parameter int READ_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW/8-1:0] req_be,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] sram_addr,
  output logic          sram_ce_n,
  output logic          sram_ce2,
  output logic          sram_oe_n,
  output logic          sram_we_n,
  output logic [DW/8-1:0] sram_bw_n,
  output logic [DW-1:0] sram_dq_out,
  input  logic [DW-1:0] sram_dq_in,
  output logic          sram_dq_oe
);
  localparam int NB = DW / 8;
  localparam int M1 = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int M2 = (HOLD_CYC > TURN_CYC) ? HOLD_CYC : TURN_CYC;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MX = (M3 > READ_CYC) ? M3 : READ_CYC;
  localparam int CW = $clog2(MX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RSET, S_RACT, S_RHOLD,
    S_WTURN, S_WSET, S_WPULSE, S_WHOLD, S_WLINGER
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q;
  logic [DW-1:0] wd_q;
  logic [NB-1:0] be_q;

  function automatic logic [CW-1:0] ld(input int n);
    return CW'(n - 1);
  endfunction

  wire open_st = (st == S_IDLE) || (st == S_WLINGER);
  wire wr_ph   = (st == S_WSET) || (st == S_WPULSE) || (st == S_WHOLD) || (st == S_WLINGER);
  wire lanes   = (st == S_RACT) || (st == S_WPULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      a_q     <= '0;
      wd_q    <= '0;
      be_q    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (open_st) begin
        st <= S_IDLE;
        if (req) begin
          if (req_be == '0) begin
            done <= 1'b1;
            if (st == S_WLINGER && req_wr) st <= S_WLINGER;
          end else begin
            a_q  <= req_addr;
            wd_q <= req_wdata;
            be_q <= req_be;
            if (!req_wr) begin
              st  <= S_RSET;
              cnt <= ld(SETUP_CYC);
            end else if (st == S_WLINGER) begin
              st  <= S_WSET;
              cnt <= ld(SETUP_CYC);
            end else begin
              st  <= S_WTURN;
              cnt <= ld(TURN_CYC);
            end
          end
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_RSET:   begin st <= S_RACT;   cnt <= ld(READ_CYC);  end
          S_RACT:   begin st <= S_RHOLD;  cnt <= ld(HOLD_CYC);  rd_data <= sram_dq_in; end
          S_RHOLD:  begin st <= S_IDLE;   done <= 1'b1; end
          S_WTURN:  begin st <= S_WSET;   cnt <= ld(SETUP_CYC); end
          S_WSET:   begin st <= S_WPULSE; cnt <= ld(PULSE_CYC); end
          S_WPULSE: begin st <= S_WHOLD;  cnt <= ld(HOLD_CYC);  end
          S_WHOLD:  begin st <= S_WLINGER; done <= 1'b1; end
          default:  st <= S_IDLE;
        endcase
      end
    end
  end

  assign sram_ce_n   = (st == S_IDLE);
  assign sram_ce2    = (st != S_IDLE);
  assign sram_oe_n   = (st != S_RACT);
  assign sram_we_n   = !wr_ph;
  assign sram_bw_n   = lanes ? ~be_q : '1;
  assign sram_dq_oe  = wr_ph;
  assign sram_addr   = a_q;
  assign sram_dq_out = wd_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW        = 19,
  parameter int DW        = 32,
  parameter int PULSE_CYC = 2,
  parameter int TURN_CYC  = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [AW-1:0] sram_addr,
  input logic          sram_ce_n,
  input logic          sram_ce2,
  input logic          sram_oe_n,
  input logic          sram_we_n,
  input logic [DW/8-1:0] sram_bw_n,
  input logic [DW-1:0] sram_dq_out,
  input logic          sram_dq_oe
);
  wire strobing = (sram_bw_n != '1);
  wire wstrobe  = strobing && !sram_we_n;
  wire turning  = !sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe;
  logic [15:0] pc, tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      tc <= '0;
    end else begin
      pc <= wstrobe ? pc + 16'd1 : 16'd0;
      tc <= turning ? tc + 16'd1 : 16'd0;
    end
  end

  p_standby_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (sram_we_n && sram_oe_n && (sram_bw_n == '1) && !sram_dq_oe && !sram_ce2));

  p_oe_we_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_oe_n && !sram_we_n));

  p_pulse_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wstrobe) |-> (pc >= 16'(PULSE_CYC)));

  p_turn_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> (tc >= 16'(TURN_CYC)) || $past(!sram_we_n, 1) == 1'b1);

  p_no_fight_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> (sram_oe_n && !sram_we_n));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sram_bw_n == '1) && sram_oe_n);

  p_frame_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (strobing && $past(strobing)) |-> ($stable(sram_addr) && $stable(sram_dq_out) && $stable(sram_bw_n)));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .TURN_CYC(TURN_CYC)
) u_chk (.*);

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SU = 2, PU = 3, HO = 1, TU = 2, RD = 2;
  localparam logic [7:0] FLOAT = 8'h5A;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_wr = 0;
  logic [18:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0]  req_be = 0;
  logic [31:0] rd_data, sram_dq_out, sram_dq_in;
  logic done, sram_ce_n, sram_ce2, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [18:0] sram_addr;
  logic [3:0]  sram_bw_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_lane_ctrl #(.SETUP_CYC(SU), .PULSE_CYC(PU), .HOLD_CYC(HO), .TURN_CYC(TU), .READ_CYC(RD)) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rd_data(rd_data), .done(done),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_ce2(sram_ce2),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_bw_n(sram_bw_n),
    .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in), .sram_dq_oe(sram_dq_oe));

  int checks = 0, failures = 0;

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Memory model driven purely by the pins; indexed by address low nibble.
  logic [31:0] mem_m [16];
  logic [31:0] gold  [16];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      if (!sram_ce_n && sram_ce2 && !sram_oe_n && sram_we_n && !sram_bw_n[k])
        sram_dq_in[8*k +: 8] = mem_m[sram_addr[3:0]][8*k +: 8];
      else
        sram_dq_in[8*k +: 8] = FLOAT;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !sram_ce_n && sram_ce2 && !sram_we_n)
      for (int k = 0; k < 4; k++)
        if (!sram_bw_n[k]) mem_m[sram_addr[3:0]][8*k +: 8] <= sram_dq_out[8*k +: 8];
  end

  typedef struct packed {
    logic ce_n; logic oe_n; logic we_n; logic [3:0] bw_n; logic dq_oe; logic dn; logic linger;
    logic chk_a; logic [18:0] a; logic chk_w; logic [31:0] w; logic chk_r; logic [31:0] r;
  } exp_t;

  exp_t q[$];
  logic last_linger = 0;

  function automatic exp_t mk(input logic ce_n, oe_n, we_n, input logic [3:0] bw, input logic dq, dn, lg);
    exp_t e = '0;
    e.ce_n = ce_n; e.oe_n = oe_n; e.we_n = we_n; e.bw_n = bw; e.dq_oe = dq; e.dn = dn; e.linger = lg;
    return e;
  endfunction

  // Cycle-by-cycle comparison against the expected pin queue.
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      e = (q.size() != 0) ? q.pop_front() : mk(1, 1, 1, 4'hF, 0, 0, 0);
      last_linger = e.linger;
      check("R1", "ce_n", sram_ce_n, e.ce_n);
      check("R1", "ce2", sram_ce2, !e.ce_n);
      check("R2", "oe_n", sram_oe_n, e.oe_n);
      check("R4", "we_n", sram_we_n, e.we_n);
      check("R11", "bw_n", sram_bw_n, e.bw_n);
      check("R7", "dq_oe", sram_dq_oe, e.dq_oe);
      check("R8", "done", done, e.dn);
      if (e.chk_a) check("R12", "addr", sram_addr, e.a);
      if (e.chk_w) check("R12", "wdata", sram_dq_out, e.w);
      if (e.chk_r) check("R3", "rd_data", rd_data, e.r);
    end
  end

  function automatic logic [31:0] rd_expect(input logic [18:0] a, input logic [3:0] be);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[8*k +: 8] = be[k] ? gold[a[3:0]][8*k +: 8] : FLOAT;
    return v;
  endfunction

  task automatic issue(input logic wr, input logic [18:0] a, input logic [31:0] d, input logic [3:0] be);
    logic held;
    exp_t e;
    held = last_linger && (q.size() == 0);
    if (be == 4'h0) begin
      if (held && wr) q.push_back(mk(0, 1, 0, 4'hF, 1, 1, 1));
      else            q.push_back(mk(1, 1, 1, 4'hF, 0, 1, 0));
    end else if (!wr) begin
      for (int i = 0; i < SU; i++) begin e = mk(0, 1, 1, 4'hF, 0, 0, 0); e.chk_a = 1; e.a = a; q.push_back(e); end
      for (int i = 0; i < RD; i++) begin e = mk(0, 0, 1, ~be, 0, 0, 0);  e.chk_a = 1; e.a = a; q.push_back(e); end
      for (int i = 0; i < HO; i++) begin e = mk(0, 1, 1, 4'hF, 0, 0, 0); e.chk_a = 1; e.a = a; q.push_back(e); end
      e = mk(1, 1, 1, 4'hF, 0, 1, 0); e.chk_r = 1; e.r = rd_expect(a, be); q.push_back(e);
    end else begin
      for (int k = 0; k < 4; k++) if (be[k]) gold[a[3:0]][8*k +: 8] = d[8*k +: 8];
      if (!held)
        for (int i = 0; i < TU; i++) begin e = mk(0, 1, 1, 4'hF, 0, 0, 0); e.chk_a = 1; e.a = a; q.push_back(e); end
      for (int i = 0; i < SU; i++) begin e = mk(0, 1, 0, 4'hF, 1, 0, 0); e.chk_a = 1; e.a = a; e.chk_w = 1; e.w = d; q.push_back(e); end
      for (int i = 0; i < PU; i++) begin e = mk(0, 1, 0, ~be, 1, 0, 0);  e.chk_a = 1; e.a = a; e.chk_w = 1; e.w = d; q.push_back(e); end
      for (int i = 0; i < HO; i++) begin e = mk(0, 1, 0, 4'hF, 1, 0, 0); e.chk_a = 1; e.a = a; e.chk_w = 1; e.w = d; q.push_back(e); end
      e = mk(0, 1, 0, 4'hF, 1, 1, 1); e.chk_a = 1; e.a = a; e.chk_w = 1; e.w = d; q.push_back(e);
    end
    req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
    @(posedge clk); #1;
    req = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (done) return;
    end
    check("R8", "done never seen", 0, 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] keep;
    int unsigned lf;
    for (int i = 0; i < 16; i++) begin mem_m[i] = 0; gold[i] = 0; end
    repeat (3) @(negedge clk);
    check("R1", "reset ce_n", sram_ce_n, 1);
    check("R1", "reset bw_n", sram_bw_n, 4'hF);
    check("R1", "reset we/oe", {sram_we_n, sram_oe_n}, 2'b11);
    check("R1", "reset dq_oe", sram_dq_oe, 0);
    check("R8", "reset done", done, 0);
    rst_n = 1;
    @(negedge clk); #1;

    // Single write from standby, then release.
    issue(1, 19'h00000, 32'h11223344, 4'hF);
    wait_done();
    @(negedge clk); #1;
    check("R6", "standby after lone write", {sram_ce_n, sram_we_n, sram_dq_oe}, 3'b110);

    issue(0, 19'h00000, 0, 4'hF);
    wait_done();
    check("R3", "full-word read", rd_data, 32'h11223344);
    @(negedge clk); #1;

    // Back-to-back chain out of the completion cycle.
    issue(1, 19'h7FFFF, 32'hA1B2C3D4, 4'b0101);
    wait_done();
    issue(1, 19'h00003, 32'hE5F60718, 4'b1010);
    @(negedge clk); #1;
    check("R5", "we held into next setup", {sram_we_n, sram_dq_oe, sram_bw_n}, {1'b0, 1'b1, 4'hF});
    wait_done();
    issue(1, 19'h00009, 32'hFFFFFFFF, 4'h0);
    @(negedge clk); #1;
    check("R9", "empty write extends linger", {done, sram_we_n, sram_bw_n}, {1'b1, 1'b0, 4'hF});
    issue(0, 19'h7FFFF, 0, 4'hF);
    @(negedge clk); #1;
    check("R10", "read releases we and bus", {sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe}, 4'b0110);
    wait_done();
    check("R11", "lanes 0 and 2 written", rd_data, 32'h00B200D4);
    @(negedge clk); #1;

    issue(0, 19'h00003, 0, 4'b0010);
    wait_done();
    check("R11", "lane 1 only read", rd_data, {FLOAT, FLOAT, 8'h07, FLOAT});
    keep = rd_data;
    @(negedge clk); #1;

    issue(0, 19'h00004, 0, 4'h0);
    @(negedge clk); #1;
    check("R9", "empty read done no strobes", {done, sram_ce_n, sram_bw_n}, {1'b1, 1'b1, 4'hF});
    check("R3", "rd_data kept", rd_data, keep);
    @(negedge clk); #1;

    // Request during a busy write is dropped.
    issue(1, 19'h00005, 32'hCAFEF00D, 4'hF);
    @(negedge clk); #1;
    req = 1; req_wr = 1; req_addr = 19'h00006; req_wdata = 32'h99999999; req_be = 4'hF;
    @(posedge clk); #1;
    req = 0;
    wait_done();
    @(negedge clk); #1;
    issue(0, 19'h00006, 0, 4'hF);
    wait_done();
    check("R13", "ignored write left memory", rd_data, 32'h0);
    issue(0, 19'h00005, 0, 4'hF);
    wait_done();
    check("R13", "accepted write intact", rd_data, 32'hCAFEF00D);

    // Mixed traffic, chained through completion cycles where possible.
    lf = 32'h1ACE5EED;
    for (int n = 0; n < 24; n++) begin
      logic w;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      w = lf[0];
      issue(w, {15'h0, 4'(8 + lf[3:1])}, lf ^ 32'h5EC0_0DE5, lf[7:4]);
      wait_done();
      if (lf[8]) begin @(negedge clk); #1; end
    end
    for (int i = 8; i < 16; i++) begin
      issue(0, 19'(i), 0, 4'hF);
      wait_done();
      check("R12", "final contents", rd_data, gold[i]);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule